// File: doc/BRIEF.md
# Response Ring Write-Pointer Controller

This block stores incoming codec responses in a circular ring that lives in system memory. Each response is a 64-bit word offered on a valid/ready stream. For every accepted response the block issues two 32-bit memory write requests on a request/acknowledge port. The low half goes to the entry address and the high half goes to the address four bytes above it. Only after both writes are acknowledged does the block advance its write pointer. The pointer names the last entry that holds valid data, not the next free slot. Several responses may arrive in quick succession, for example within one link frame, and each one is stored and counted on its own.

Software reaches the block through a small register port with a write strobe, a 3-bit word offset and a combinational read bus. Through this port it sets the 64-bit ring base as two halves, starts and stops the engine, sets a response-count interrupt threshold, resets the pointer, and reads and clears a sticky interrupt status. The status is also driven on the `irq` output.

Top module: `resp_ring_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `rspReady` is low.
- R2: `rspReady` is high only while the run bit (offset 4, bit 0) is 1 and no entry write is in progress. With run clear, no memory request is issued and the pointer does not move.
- R3: After a pointer reset, the first stored response goes to entry index 1. Each stored response then advances the pointer by exactly one, wrapping from 255 to 0.
- R4: Entry index i is written at address {baseHi, baseLo} + 8*i, with a full 64-bit carry. Data bits 31:0 go to that address first, then bits 63:32 go to that address plus 4. A request holds its address and data steady until it is acknowledged.
- R5: The pointer changes only after the second write of an entry has been acknowledged. While an entry's writes are pending, the pointer still reads as the previous index.
- R6: The pointer register (offset 2) returns the pointer in bits 7:0 and zeros in bits 31:8. Writing it with bit 15 set clears both the pointer and the response counter.
- R7: Every stored response counts once. When the count reaches the threshold (offset 3, bits 7:0), the status bit is set and the count restarts from 0. Threshold codes 1 to 255 mean that many responses, and code 0 means 256.
- R8: The status bit (offset 5, bit 0, also driven on `irq`) stays set until software writes 1 to that bit.
- R9: A threshold write has no effect while the run bit is 1.
- R10: The base halves (offset 0 low, offset 1 high) are read/write and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| rspValid | input | 1 | Response word valid |
| rspData | input | 64 | Response word |
| rspReady | output | 1 | Block accepts a response this cycle |
| memReqValid | output | 1 | Memory write request pending |
| memReqAddr | output | 64 | Memory write byte address |
| memReqData | output | 32 | Memory write data |
| memReqAck | input | 1 | Memory accepts the pending request |
| irq | output | 1 | Sticky response interrupt status |

## Verification
The assertions assume that `memReqAck` is high only while a request is pending, and that a response, once offered, is held until it is taken. The bench drives both sides at falling edges. Its memory model raises the acknowledge for exactly one cycle, and only after it has seen a pending request. The response driver holds `rspValid` and the data until it observes `rspReady` high. Threshold and base changes are made only while the engine is stopped and idle, except for the single write that deliberately tests that a threshold write is ignored while the engine runs.

// File: rtl/resp_ring_pkg.sv
package resp_ring_pkg;

  // register word offsets
  localparam logic [2:0] REG_BASE_LO = 3'd0;
  localparam logic [2:0] REG_BASE_HI = 3'd1;
  localparam logic [2:0] REG_PTR     = 3'd2;
  localparam logic [2:0] REG_THR     = 3'd3;
  localparam logic [2:0] REG_CTRL    = 3'd4;
  localparam logic [2:0] REG_STAT    = 3'd5;

  // bit position of the write-1 pointer clear in the pointer register
  localparam int PTR_CLR_BIT = 15;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WR_LO = 2'd1,
    ST_WR_HI = 2'd2
  } ringState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the accepted response word
    logic selHi;    // second half of the entry is on the bus
    logic commit;   // both halves acknowledged: advance pointer and count
  } ringStrobe_t;

endpackage

// File: rtl/resp_ring_ctl.sv
module resp_ring_ctl
  import resp_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        rspValid,
  input  logic        memReqAck,
  output logic        rspReady,
  output logic        memReqValid,
  output ringStrobe_t strobe
);

  ringState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    rspReady       = 1'b0;
    memReqValid    = 1'b0;
    strobe         = '0;
    unique case (state)
      ST_IDLE: begin
        rspReady = runEn;
        if (runEn && rspValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_WR_LO;
        end
      end
      ST_WR_LO: begin
        memReqValid = 1'b1;
        if (memReqAck) stateNext = ST_WR_HI;
      end
      ST_WR_HI: begin
        memReqValid  = 1'b1;
        strobe.selHi = 1'b1;
        if (memReqAck) begin
          strobe.commit = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/resp_ring_dp.sv
module resp_ring_dp
  import resp_ring_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  input  logic [2*WORD_W-1:0] rspData,
  input  ringStrobe_t         strobe,
  output logic [2*WORD_W-1:0] memReqAddr,
  output logic [WORD_W-1:0]   memReqData,
  output logic                runEn,
  output logic [PTR_W-1:0]    wrPtr,
  output logic                irqStat
);

  localparam int ADDR_W      = 2 * WORD_W;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int ENTRY_SHIFT = $clog2(2 * WORD_BYTES);
  localparam int CNT_W       = PTR_W + 1;

  logic [WORD_W-1:0]   baseLo, baseHi;
  logic [PTR_W-1:0]    thrCode;
  logic [CNT_W-1:0]    rspCnt, cntNext, thrLimit;
  logic [2*WORD_W-1:0] rspBuf;
  logic [PTR_W-1:0]    nextIdx;
  logic                wrBaseLo, wrBaseHi, wrPtrReg, wrThr, wrCtrl, wrStat;
  logic                ptrClr, irqClr, hitThr;

  assign wrBaseLo = regWrEn && (regAddr == REG_BASE_LO);
  assign wrBaseHi = regWrEn && (regAddr == REG_BASE_HI);
  assign wrPtrReg = regWrEn && (regAddr == REG_PTR);
  assign wrThr    = regWrEn && (regAddr == REG_THR);
  assign wrCtrl   = regWrEn && (regAddr == REG_CTRL);
  assign wrStat   = regWrEn && (regAddr == REG_STAT);

  assign ptrClr = wrPtrReg && regWrData[PTR_CLR_BIT];
  assign irqClr = wrStat && regWrData[0];

  assign nextIdx  = wrPtr + 1'b1;
  assign cntNext  = rspCnt + 1'b1;
  assign thrLimit = (thrCode == '0) ? (CNT_W'(1) << PTR_W) : {1'b0, thrCode};
  assign hitThr   = strobe.commit && !ptrClr && (cntNext == thrLimit);

  // software-owned configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLo  <= '0;
      baseHi  <= '0;
      thrCode <= '0;
      runEn   <= 1'b0;
    end else begin
      if (wrBaseLo) baseLo <= regWrData;
      if (wrBaseHi) baseHi <= regWrData;
      if (wrThr && !runEn) thrCode <= regWrData[PTR_W-1:0];
      if (wrCtrl) runEn <= regWrData[0];
    end
  end

  // response capture
  always_ff @(posedge clk) begin
    if (!rstN)               rspBuf <= '0;
    else if (strobe.capture) rspBuf <= rspData;
  end

  // pointer and response counter; a pointer clear wins over a commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rspCnt <= '0;
    end else if (ptrClr) begin
      wrPtr  <= '0;
      rspCnt <= '0;
    end else if (strobe.commit) begin
      wrPtr  <= nextIdx;
      rspCnt <= hitThr ? '0 : cntNext;
    end
  end

  // sticky status: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN)       irqStat <= 1'b0;
    else if (hitThr) irqStat <= 1'b1;
    else if (irqClr) irqStat <= 1'b0;
  end

  // entry address for the pending write
  always_comb begin
    memReqAddr = {baseHi, baseLo}
               + (ADDR_W'(nextIdx) << ENTRY_SHIFT)
               + (strobe.selHi ? ADDR_W'(WORD_BYTES) : ADDR_W'(0));
    memReqData = strobe.selHi ? rspBuf[2*WORD_W-1:WORD_W] : rspBuf[WORD_W-1:0];
  end

  // register read mux
  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_BASE_LO: regRdData = baseLo;
      REG_BASE_HI: regRdData = baseHi;
      REG_PTR:     regRdData = WORD_W'(wrPtr);
      REG_THR:     regRdData = WORD_W'(thrCode);
      REG_CTRL:    regRdData = WORD_W'(runEn);
      REG_STAT:    regRdData = WORD_W'(irqStat);
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/resp_ring_ctrl.sv
module resp_ring_ctrl
  import resp_ring_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  input  logic                rspValid,
  input  logic [2*WORD_W-1:0] rspData,
  output logic                rspReady,
  output logic                memReqValid,
  output logic [2*WORD_W-1:0] memReqAddr,
  output logic [WORD_W-1:0]   memReqData,
  input  logic                memReqAck,
  output logic                irq
);

  ringStrobe_t      strobe;
  logic             runEn;
  logic [PTR_W-1:0] wrPtr;

  resp_ring_ctl ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .runEn       (runEn),
    .rspValid    (rspValid),
    .memReqAck   (memReqAck),
    .rspReady    (rspReady),
    .memReqValid (memReqValid),
    .strobe      (strobe)
  );

  resp_ring_dp #(.WORD_W(WORD_W), .PTR_W(PTR_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .rspData    (rspData),
    .strobe     (strobe),
    .memReqAddr (memReqAddr),
    .memReqData (memReqData),
    .runEn      (runEn),
    .wrPtr      (wrPtr),
    .irqStat    (irq)
  );

endmodule

// File: rtl/resp_ring_chk.sv
module resp_ring_chk
  import resp_ring_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PTR_W  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [2:0]          regAddr,
  input logic [WORD_W-1:0]   regWrData,
  input logic [WORD_W-1:0]   regRdData,
  input logic                rspReady,
  input logic                memReqValid,
  input logic [2*WORD_W-1:0] memReqAddr,
  input logic [WORD_W-1:0]   memReqData,
  input logic                memReqAck,
  input logic                irq,
  input logic                runEn,
  input logic [PTR_W-1:0]    wrPtr
);

  logic ptrClrWr, statClrWr;
  assign ptrClrWr  = regWrEn && (regAddr == REG_PTR) && regWrData[PTR_CLR_BIT];
  assign statClrWr = regWrEn && (regAddr == REG_STAT) && regWrData[0];

  // R2
  no_ready_during_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rspReady && memReqValid));

  // R2
  ready_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> runEn);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqAck) |=> (memReqValid && $stable(memReqAddr) && $stable(memReqData)));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr != $past(wrPtr)) |-> ((wrPtr == $past(wrPtr) + 1'b1) || (wrPtr == '0)));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqAck && !ptrClrWr) |=> $stable(wrPtr));

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !statClrWr) |=> irq);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memReqValid && memReqAck));

  // R6
  ptr_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_PTR) |-> (regRdData[WORD_W-1:PTR_W] == '0));

endmodule

bind resp_ring_ctrl resp_ring_chk #(.WORD_W(WORD_W), .PTR_W(PTR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .rspReady    (rspReady),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memReqData  (memReqData),
  .memReqAck   (memReqAck),
  .irq         (irq),
  .runEn       (runEn),
  .wrPtr       (wrPtr)
);

// File: tb/resp_ring_ctrl_tb_top.sv
module resp_ring_ctrl_tb_top;

  localparam logic [2:0] A_BLO = 3'd0, A_BHI = 3'd1, A_PTR = 3'd2,
                         A_THR = 3'd3, A_CTL = 3'd4, A_STA = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rspValid = 1'b0;
  logic [63:0] rspData = '0;
  logic        rspReady;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic [31:0] memReqData;
  logic        memReqAck = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int ackDelay = 1;
  int waitCnt = 0;
  bit done = 1'b0;
  logic [7:0]  expIdx = '0;
  logic [31:0] expLo = '0, expHi = '0;
  logic [95:0] expQ[$];

  always #2 clk = ~clk;

  resp_ring_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rspValid(rspValid),
    .rspData(rspData), .rspReady(rspReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqAck(memReqAck),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // driver: pushes the two expected writes, then hands over the response
  task automatic sendRsp(input logic [63:0] d);
    logic [63:0] base;
    expIdx = expIdx + 1'b1;
    base = {expHi, expLo} + {53'd0, expIdx, 3'd0};
    expQ.push_back({base, d[31:0]});
    expQ.push_back({base + 64'd4, d[63:32]});
    @(negedge clk);
    rspValid = 1'b1; rspData = d;
    while (!rspReady) @(negedge clk);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor and memory model
  initial begin
    forever begin
      @(negedge clk);
      if (memReqAck) begin
        memReqAck = 1'b0;
      end else if (memReqValid) begin
        if (waitCnt >= ackDelay) begin
          logic [95:0] e;
          if (expQ.size() == 0) begin
            chk(1'b0, "R4 unexpected write", memReqAddr, 64'd0);
          end else begin
            e = expQ.pop_front();
            chk(memReqAddr == e[95:32], "R4 address", memReqAddr, e[95:32]);
            chk(memReqData == e[31:0], "R4 data", {32'd0, memReqData}, {32'd0, e[31:0]});
          end
          memReqAck = 1'b1;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit sawBad;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), rd);
      chk(rd == 32'd0, "R1 register reset", {32'd0, rd}, 64'd0);
    end
    chk(irq == 1'b0, "R1 irq reset", {63'd0, irq}, 64'd0);
    chk(rspReady == 1'b0, "R1 ready reset", {63'd0, rspReady}, 64'd0);

    // R10 base halves
    regWrite(A_BHI, 32'h1234_5678);
    regRead(A_BHI, rd);
    chk(rd == 32'h1234_5678, "R10 base high", {32'd0, rd}, 64'h1234_5678);
    regWrite(A_BLO, 32'h0040_0000);
    regRead(A_BLO, rd);
    chk(rd == 32'h0040_0000, "R10 base low", {32'd0, rd}, 64'h0040_0000);
    expHi = 32'h1234_5678; expLo = 32'h0040_0000;

    // R2 stopped engine ignores the stream
    @(negedge clk);
    rspValid = 1'b1; rspData = 64'hdead_beef_0bad_f00d;
    sawBad = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (rspReady || memReqValid) sawBad = 1'b1;
    end
    rspValid = 1'b0;
    chk(!sawBad, "R2 no ready or request while stopped", {63'd0, sawBad}, 64'd0);
    regRead(A_PTR, rd);
    chk(rd == 32'd0, "R2 pointer unchanged while stopped", {32'd0, rd}, 64'd0);

    // R7 threshold of three, back-to-back responses
    regWrite(A_THR, 32'd3);
    regWrite(A_CTL, 32'd1);
    sendRsp(64'h1111_2222_3333_4444);
    sendRsp(64'h5555_6666_7777_8888);
    drain();
    regRead(A_PTR, rd);
    chk(rd == 32'd2, "R3 pointer after two", {32'd0, rd}, 64'd2);
    chk(irq == 1'b0, "R7 no irq below threshold", {63'd0, irq}, 64'd0);
    sendRsp(64'h9999_aaaa_bbbb_cccc);
    drain();
    chk(irq == 1'b1, "R7 irq at threshold", {63'd0, irq}, 64'd1);
    regRead(A_PTR, rd);
    chk(rd == 32'd3, "R3 pointer after three", {32'd0, rd}, 64'd3);

    // R9 threshold write ignored while running
    regWrite(A_THR, 32'd5);
    regRead(A_THR, rd);
    chk(rd == 32'd3, "R9 threshold locked while running", {32'd0, rd}, 64'd3);

    // R8 sticky status and write-1 clear
    sendRsp(64'h0102_0304_0506_0708);
    drain();
    chk(irq == 1'b1, "R8 irq stays set", {63'd0, irq}, 64'd1);
    regWrite(A_STA, 32'd1);
    regRead(A_STA, rd);
    chk(rd == 32'd0 && irq == 1'b0, "R8 status cleared", {32'd0, rd}, 64'd0);

    // R5 pointer holds while the entry is still being written
    ackDelay = 12;
    sendRsp(64'hcafe_0000_face_0001);
    repeat (4) @(negedge clk);
    regRead(A_PTR, rd);
    chk(rd == 32'd4, "R5 pointer before acks", {32'd0, rd}, 64'd4);
    drain();
    ackDelay = 1;
    regRead(A_PTR, rd);
    chk(rd == 32'd5, "R5 pointer after acks", {32'd0, rd}, 64'd5);

    // R6 pointer clear also clears the counter (count was 2 of 3)
    regWrite(A_PTR, 32'h0000_8000);
    expIdx = '0;
    regRead(A_PTR, rd);
    chk(rd == 32'd0, "R6 pointer cleared, upper bits zero", {32'd0, rd}, 64'd0);
    sendRsp(64'h0000_0001_0000_0002);
    drain();
    regRead(A_PTR, rd);
    chk(rd == 32'd1, "R3 first entry after clear is 1", {32'd0, rd}, 64'd1);
    chk(irq == 1'b0, "R6 counter cleared by pointer reset", {63'd0, irq}, 64'd0);
    sendRsp(64'h0000_0003_0000_0004);
    sendRsp(64'h0000_0005_0000_0006);
    drain();
    chk(irq == 1'b1, "R7 irq after three fresh responses", {63'd0, irq}, 64'd1);

    // R7 code 0 means 256, R3 wrap, R4 carry into the upper half
    regWrite(A_CTL, 32'd0);
    regWrite(A_THR, 32'd0);
    regWrite(A_BLO, 32'hFFFF_FFF0);
    expLo = 32'hFFFF_FFF0;
    regWrite(A_STA, 32'd1);
    regWrite(A_PTR, 32'h0000_8000);
    expIdx = '0;
    regWrite(A_CTL, 32'd1);
    for (int n = 0; n < 255; n++) sendRsp({32'(n), 32'(~n)});
    drain();
    regRead(A_PTR, rd);
    chk(rd == 32'd255, "R3 pointer at 255", {32'd0, rd}, 64'd255);
    chk(irq == 1'b0, "R7 no irq at 255 of 256", {63'd0, irq}, 64'd0);
    sendRsp(64'hfeed_0000_beef_0000);
    drain();
    regRead(A_PTR, rd);
    chk(rd == 32'd0, "R3 pointer wraps to 0", {32'd0, rd}, 64'd0);
    chk(irq == 1'b1, "R7 irq at 256 with code 0", {63'd0, irq}, 64'd1);
    chk(expQ.size() == 0, "R4 all writes seen", 64'(expQ.size()), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule